// File: doc/BRIEF.md
# Aggregated Peripheral Interrupt Controller

This block gathers up to 32 level-sensitive peripheral interrupt requests into one status register and masks them with one enable register. A source counts as pending only when its status bit and its enable bit are both set. The OR of all pending sources drives one line of a CPU interrupt input vector. That line is bit 6 by default, and every other bit of the vector stays low. For service, the block reports the index of the lowest-numbered pending source together with a valid flag.

Software reaches the two registers over a simple single-cycle register bus. It unmasks or masks a source by a read-modify-write of the enable register. It acknowledges a source by writing the status register back with that source's bit cleared. Once the lowest source has been acknowledged, the index moves on to the next lowest pending source. If the combined line is still high in a cycle where nothing is pending, a spurious flag shows for that cycle. This happens, for example, just after the last acknowledge. Source input 5 is, by convention, wired to the performance-counter interrupt. The block treats it like any other source.

Top module: `agg_irq_ctrl`

## Requirements
- R1: While reset is held and right after it, the status and enable registers read zero, and cpu_ip_o, pend_vld_o and spurious_o are all low.
- R2: A high level on src_i[k] at a clock edge sets status bit k at that edge. The bit stays set while the source is high, even when a write in the same cycle tries to clear it, and it stays set after the source falls until it is acknowledged.
- R3: A bus write to address 0 (status) clears every status bit whose write-data bit is 0. A write-data bit of 1 leaves its status bit unchanged, so software can never set a status bit.
- R4: A bus write to address 1 (enable) replaces the whole enable register with the write data. Bit k set to 1 unmasks source k, and set to 0 masks it.
- R5: A source whose enable bit is 0 never raises the combined line and never appears in the pending index, even while its status bit is set.
- R6: cpu_ip_o bit CPU_LINE (default 6) is high exactly one cycle after a cycle in which at least one source is pending, and all other bits of cpu_ip_o are always 0.
- R7: pend_idx_o gives the lowest index k for which status and enable bits are both 1, with pend_vld_o high. pend_vld_o is low when no source is pending.
- R8: After the lowest pending source is acknowledged, pend_idx_o shows the next lowest pending source from the following cycle on.
- R9: spurious_o is high in exactly those cycles where the combined line is high and no source is pending.
- R10: bus_rdata_o shows the register picked by bus_addr_i (0 status, 1 enable), and a read in the cycle after a write returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level-sensitive peripheral interrupt sources |
| bus_sel_i | input | 1 | Register bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 1 | Register select: 0 status, 1 enable |
| bus_wdata_i | input | NSRC | Write data |
| bus_rdata_o | output | NSRC | Read data of the selected register |
| cpu_ip_o | output | NCPU | CPU interrupt input vector, only bit CPU_LINE driven |
| pend_idx_o | output | $clog2(NSRC) | Lowest pending source index |
| pend_vld_o | output | 1 | Pending index is valid |
| spurious_o | output | 1 | Combined line high with empty pending set |

## Verification
The priority encoder is driven with one pending source at a time, with three enabled sources plus one masked source that are acknowledged one by one, and with the two extreme indices 0 and 31 pending together. Together these separate lowest-first order from highest-first order, from arrival order and from a report that ignores the mask. Pulsing a source while it is masked and then unmasking it separates masking at the output from masking at capture. Holding a source high through a clear write, and writing all ones to status, separates level capture from edge capture and write-one-to-clear from write-zero-to-clear. The last acknowledge leaves the line high for one cycle with nothing pending, which exposes the spurious flag and the one-cycle registered delay of the line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_ENABLE = 1'b1
    } irqc_reg_e;
endpackage

// File: rtl/irqc_src_latch.sv
module irqc_src_latch #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            ack_we_i,
    input  logic [NSRC-1:0] ack_keep_i,
    output logic [NSRC-1:0] status_o
);
    typedef struct packed {
        logic [NSRC-1:0] status;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_we_i) begin
            st_d.status = st_q.status & ack_keep_i;
        end
        // a live source wins over any clear in the same cycle
        st_d.status = st_d.status | src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] enable_o
);
    typedef struct packed {
        logic [NSRC-1:0] enable;
    } mask_t;

    mask_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (we_i) begin
            mk_d.enable = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mk_q <= '0;
        end else begin
            mk_q <= mk_d;
        end
    end

    assign enable_o = mk_q.enable;
endmodule

// File: rtl/irqc_first_set.sv
module irqc_first_set #(
    parameter int NSRC = 32,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] vec_i,
    output logic [IW-1:0]   idx_o,
    output logic            vld_o
);
    logic [NSRC-1:0] below_any;
    logic [NSRC-1:0] first_hot;

    // below_any[k] is high when some bit under k is set
    assign below_any[0] = 1'b0;
    for (genvar g = 1; g < NSRC; g++) begin : g_chain
        assign below_any[g] = below_any[g-1] | vec_i[g-1];
    end

    assign first_hot = vec_i & ~below_any;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (first_hot[i]) begin
                idx_o = idx_o | IW'(i);
            end
        end
    end

    assign vld_o = |vec_i;
endmodule

// File: rtl/agg_irq_ctrl.sv
module agg_irq_ctrl #(
    parameter int NSRC     = 32,
    parameter int NCPU     = 8,
    parameter int CPU_LINE = 6,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            bus_sel_i,
    input  logic            bus_we_i,
    input  logic            bus_addr_i,
    input  logic [NSRC-1:0] bus_wdata_i,
    output logic [NSRC-1:0] bus_rdata_o,
    output logic [NCPU-1:0] cpu_ip_o,
    output logic [IW-1:0]   pend_idx_o,
    output logic            pend_vld_o,
    output logic            spurious_o
);
    import irqc_pkg::*;

    typedef struct packed {
        logic irq;
    } top_t;

    top_t top_d, top_q;

    logic            wr_status;
    logic            wr_enable;
    logic [NSRC-1:0] status_w;
    logic [NSRC-1:0] enable_w;
    logic [NSRC-1:0] pending_w;
    logic            any_pend;

    assign wr_status = bus_sel_i && bus_we_i && (irqc_reg_e'(bus_addr_i) == REG_STATUS);
    assign wr_enable = bus_sel_i && bus_we_i && (irqc_reg_e'(bus_addr_i) == REG_ENABLE);

    irqc_src_latch #(.NSRC(NSRC)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .ack_we_i   (wr_status),
        .ack_keep_i (bus_wdata_i),
        .status_o   (status_w)
    );

    irqc_mask_reg #(.NSRC(NSRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (wr_enable),
        .wdata_i  (bus_wdata_i),
        .enable_o (enable_w)
    );

    assign pending_w = status_w & enable_w;

    irqc_first_set #(.NSRC(NSRC)) u_first (
        .vec_i (pending_w),
        .idx_o (pend_idx_o),
        .vld_o (any_pend)
    );

    always_comb begin
        top_d     = top_q;
        top_d.irq = any_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    always_comb begin
        if (irqc_reg_e'(bus_addr_i) == REG_ENABLE) begin
            bus_rdata_o = enable_w;
        end else begin
            bus_rdata_o = status_w;
        end
    end

    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        if (g == CPU_LINE) begin : g_on
            assign cpu_ip_o[g] = top_q.irq;
        end else begin : g_off
            assign cpu_ip_o[g] = 1'b0;
        end
    end

    assign pend_vld_o = any_pend;
    assign spurious_o = top_q.irq && !any_pend;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NSRC     = 32,
    parameter int NCPU     = 8,
    parameter int CPU_LINE = 6,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_i,
    input logic            bus_sel_i,
    input logic            bus_we_i,
    input logic            bus_addr_i,
    input logic [NSRC-1:0] bus_wdata_i,
    input logic [NCPU-1:0] cpu_ip_o,
    input logic [IW-1:0]   pend_idx_o,
    input logic            pend_vld_o,
    input logic            spurious_o,
    input logic [NSRC-1:0] status_w,
    input logic [NSRC-1:0] enable_w
);
    logic line;
    assign line = cpu_ip_o[CPU_LINE];

    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((status_w & $past(src_i)) == $past(src_i))); // R2

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_we_i && bus_addr_i) |=> (enable_w == $past(bus_wdata_i))); // R4

    AST_NO_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_we_i && !bus_addr_i)
        |=> ((status_w & ~$past(status_w) & ~$past(src_i)) == '0)); // R3

    AST_IDX_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld_o |-> (status_w[pend_idx_o] && enable_w[pend_idx_o])); // R5

    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld_o |-> (((status_w & enable_w) & ((NSRC'(1) << pend_idx_o) - NSRC'(1))) == '0)); // R7

    AST_LINE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_ip_o) && ((cpu_ip_o & ~(NCPU'(1) << CPU_LINE)) == '0)); // R6

    AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (line == $past(pend_vld_o))); // R6

    AST_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        spurious_o |-> (line && !pend_vld_o)); // R9
endmodule

bind agg_irq_ctrl irqc_checker #(
    .NSRC     (NSRC),
    .NCPU     (NCPU),
    .CPU_LINE (CPU_LINE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .cpu_ip_o    (cpu_ip_o),
    .pend_idx_o  (pend_idx_o),
    .pend_vld_o  (pend_vld_o),
    .spurious_o  (spurious_o),
    .status_w    (status_w),
    .enable_w    (enable_w)
);

// File: tb/agg_irq_ctrl_bench.sv
module agg_irq_ctrl_bench;
    localparam int K_RDS = 0;   // status read-back
    localparam int K_RDE = 1;   // enable read-back
    localparam int K_CPU = 2;
    localparam int K_IDX = 3;
    localparam int K_VLD = 4;
    localparam int K_SPU = 5;

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] val;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_sel_i = 1'b0;
    logic        bus_we_i = 1'b0;
    logic        bus_addr_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [7:0]  cpu_ip_o;
    logic [4:0]  pend_idx_o;
    logic        pend_vld_o;
    logic        spurious_o;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t expq[$];
    logic rd_sel = 1'b0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    agg_irq_ctrl u_agg_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .bus_sel_i   (bus_sel_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .cpu_ip_o    (cpu_ip_o),
        .pend_idx_o  (pend_idx_o),
        .pend_vld_o  (pend_vld_o),
        .spurious_o  (spurious_o)
    );

    // read address is steered by the pending expectations at sample time
    always_comb bus_addr_i = bus_we_i ? rd_sel : rd_sel;

    task automatic push(input string tag, input int kind, input logic [31:0] val);
        exp_t e;
        e.tag = tag; e.kind = kind; e.val = val;
        expq.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic bus_write(input logic adr, input logic [31:0] data);
        bus_sel_i = 1'b1; bus_we_i = 1'b1; rd_sel = adr; bus_wdata_i = data;
        tick();
        bus_sel_i = 1'b0; bus_we_i = 1'b0; bus_wdata_i = '0;
    endtask

    // monitor: pops every expectation in the half cycle after the edge
    initial begin
        forever begin
            @(negedge clk);
            while (expq.size() > 0) begin
                exp_t e;
                logic [31:0] act;
                e = expq.pop_front();
                case (e.kind)
                    K_RDS: begin rd_sel = 1'b0; #0; #0; act = bus_rdata_o; end
                    K_RDE: begin rd_sel = 1'b1; #0; #0; act = bus_rdata_o; end
                    K_CPU: act = {24'd0, cpu_ip_o};
                    K_IDX: act = {27'd0, pend_idx_o};
                    K_VLD: act = {31'd0, pend_vld_o};
                    default: act = {31'd0, spurious_o};
                endcase
                n_chk++;
                if (act !== e.val) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", e.tag, e.kind, act, e.val);
                end
            end
        end
    end

    task automatic all_idle(input string tag, input logic [31:0] st, input logic [31:0] en);
        push(tag, K_RDS, st);
        push(tag, K_RDE, en);
        push(tag, K_CPU, 32'h0);
        push(tag, K_VLD, 32'h0);
        push(tag, K_SPU, 32'h0);
    endtask

    task automatic wait_mon();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        #2;
        tick();
        all_idle("R1 in reset", 32'h0, 32'h0);
        wait_mon();
        rst_n = 1'b1;
        tick();
        all_idle("R1 after reset", 32'h0, 32'h0);
        wait_mon();

        // R4 / R10: enable writes and read-modify-write
        bus_write(1'b1, 32'h0000_0024);
        push("R10 enable readback", K_RDE, 32'h0000_0024);
        wait_mon();
        bus_write(1'b1, 32'h0000_0024 | 32'h200);
        push("R4 rmw set bit 9", K_RDE, 32'h0000_0224);
        wait_mon();
        bus_write(1'b1, 32'h0000_0204);
        push("R4 rmw clear bit 5", K_RDE, 32'h0000_0204);
        wait_mon();

        // R5: masked source latches but stays silent
        src_i = 32'h20;
        tick();
        src_i = '0;
        push("R2 pulse latched", K_RDS, 32'h20);
        push("R5 masked no valid", K_VLD, 32'h0);
        wait_mon();
        tick();
        push("R5 masked line low", K_CPU, 32'h0);
        push("R2 latch holds", K_RDS, 32'h20);
        wait_mon();

        // unmask: index now, line one cycle later
        bus_write(1'b1, 32'h0000_0224);
        push("R7 idx 5", K_IDX, 32'd5);
        push("R7 valid", K_VLD, 32'h1);
        push("R6 line not yet", K_CPU, 32'h0);
        wait_mon();
        tick();
        push("R6 line on bit 6", K_CPU, 32'h40);
        wait_mon();

        // several sources, one masked (bit 20)
        src_i = 32'h0010_0204;
        tick();
        src_i = '0;
        push("R2 multi latched", K_RDS, 32'h0010_0224);
        push("R7 lowest is 2", K_IDX, 32'd2);
        wait_mon();
        bus_write(1'b0, 32'h0010_0220);
        push("R8 next is 5", K_IDX, 32'd5);
        push("R3 ack bit 2", K_RDS, 32'h0010_0220);
        wait_mon();
        bus_write(1'b0, 32'h0010_0200);
        push("R8 next is 9", K_IDX, 32'd9);
        push("R9 no spurious", K_SPU, 32'h0);
        wait_mon();
        bus_write(1'b0, 32'h0010_0000);
        push("R7 none valid low", K_VLD, 32'h0);
        push("R9 spurious pulse", K_SPU, 32'h1);
        push("R9 line still high", K_CPU, 32'h40);
        wait_mon();
        tick();
        push("R9 spurious ends", K_SPU, 32'h0);
        push("R6 line drops", K_CPU, 32'h0);
        push("R5 masked bit kept", K_RDS, 32'h0010_0000);
        wait_mon();

        // R3: writing ones cannot set, zeros clear
        bus_write(1'b0, 32'hFFFF_FFFF);
        push("R3 ones no set", K_RDS, 32'h0010_0000);
        wait_mon();
        bus_write(1'b0, 32'h0);
        push("R3 zero clears", K_RDS, 32'h0);
        wait_mon();

        // R2: level held through a clear write
        src_i = 32'h200;
        tick();
        bus_write(1'b0, 32'h0);
        push("R2 held over clear", K_RDS, 32'h200);
        wait_mon();
        src_i = '0;
        bus_write(1'b0, 32'h0);
        push("R2 clear after drop", K_RDS, 32'h0);
        wait_mon();

        // extremes: bits 31 and 0
        bus_write(1'b1, 32'hFFFF_FFFF);
        src_i = 32'h8000_0000;
        tick();
        src_i = '0;
        push("R7 idx 31", K_IDX, 32'd31);
        wait_mon();
        src_i = 32'h1;
        tick();
        src_i = '0;
        push("R7 idx 0 over 31", K_IDX, 32'd0);
        wait_mon();
        bus_write(1'b0, 32'h8000_0000);
        push("R8 back to 31", K_IDX, 32'd31);
        wait_mon();

        done = 1'b1;
        finish_run();
    end
endmodule